// File: doc/BRIEF.md
# Paired Control-Strobe Decoder

This block turns one 8-bit field of a microcode control word into two groups of active-low register strobes. The low nibble picks the module that may drive the data bus. The high nibble picks the module that loads from the bus. Each nibble is decoded by a pair of 3-to-8 decoders. Bit 3 of the nibble enables one decoder of the pair, and bits 2..0 pick the output inside it. The result is 16 read strobes and 16 write strobes.

Each nibble is a single code, and code zero drives no strobe at all. Because of this, a control word can never turn on two bus drivers or two loaders at the same time. Position 0 of each group is left unconnected, so 30 strobes can be used.

For programming memory from outside, a loader-override input replaces the control-word field with an external 8-bit value. The outside agent can then select, for example, the memory-address register and the RAM write strobe. The block is purely combinational.

Top module: `ctl_strobe_decoder`

## Requirements
- R1: While `ldr_active_i` is 0, the decoded source is `ctl_field_i`. Its bits 3..0 are the read code and its bits 7..4 are the write code.
- R2: While `ldr_active_i` is 1, the decoded source is `ldr_value_i`, with the same bit split. `ctl_field_i` then has no effect on either strobe group.
- R3: For a read code c in 1..15, `rd_strb_n_o[c]` is 0 and every other read strobe is 1.
- R4: For a write code c in 1..15, `wr_strb_n_o[c]` is 0 and every other write strobe is 1.
- R5: Code 0 in a nibble leaves all 16 strobes of that group at 1. Bit 0 of each group is therefore 1 for every input.
- R6: At any input, at most one strobe in each group is 0.
- R7: Every strobe is active-low, and the idle level is 1.
- R8: Within a code, bit 3 chooses the decoder. Codes 8..15 land on strobes 8..15, which come from the upper decoder of the pair. Codes 0..7 land on strobes 0..7, which come from the lower decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_field_i | input | 8 | Strobe field of the control word: [3:0] read code, [7:4] write code |
| ldr_active_i | input | 1 | High while an external loader owns the strobes |
| ldr_value_i | input | 8 | External code used while the loader is active, same split |
| rd_strb_n_o | output | 16 | Active-low bus-read (output-enable) strobes |
| wr_strb_n_o | output | 16 | Active-low bus-write (load-enable) strobes |

## Verification
The block is combinational, so a wrong selection shows in the same evaluation as the input that causes it. It can appear in three ways:
- a strobe low at the wrong index;
- two strobes low in one group;
- a strobe low for code zero.

A source multiplexer stuck on the wrong side shows up as a strobe group that follows the ignored input. The bench therefore changes the ignored input while the other input is held fixed. Sweeping every field value with the override both off and on reaches every decoder output and every enable combination.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  // Select width of one 3-to-8 decoder
  localparam int unsigned STRB_SEL_W  = 3;
  // Decoders per group (one read pair, one write pair)
  localparam int unsigned STRB_PAIR_N = 2;
  // Derived widths
  localparam int unsigned STRB_DEC_OUT = 1 << STRB_SEL_W;
  localparam int unsigned STRB_CODE_W  = STRB_SEL_W + 1;
  localparam int unsigned STRB_GRP_W   = STRB_PAIR_N * STRB_DEC_OUT;
  localparam int unsigned STRB_FIELD_W = 2 * STRB_CODE_W;

  typedef logic [STRB_CODE_W-1:0]  strb_code_t;
  typedef logic [STRB_FIELD_W-1:0] strb_field_t;
  typedef logic [STRB_GRP_W-1:0]   strb_grp_t;

  // Split helpers, so the bench can restate the split on its own
  function automatic strb_code_t rd_code_of(input strb_field_t f);
    return f[STRB_CODE_W-1:0];
  endfunction

  function automatic strb_code_t wr_code_of(input strb_field_t f);
    return f[STRB_FIELD_W-1:STRB_CODE_W];
  endfunction

  // Decoder-select part and in-decoder part of a code
  function automatic logic bank_of(input strb_code_t c);
    return c[STRB_CODE_W-1];
  endfunction

  function automatic logic [STRB_SEL_W-1:0] line_of(input strb_code_t c);
    return c[STRB_SEL_W-1:0];
  endfunction
endpackage

// File: rtl/strobe_src_sel.sv
module strobe_src_sel
  import strobe_pkg::*;
(
  input  strb_field_t ctl_field_i,
  input  logic        ldr_active_i,
  input  strb_field_t ldr_value_i,
  output strb_field_t src_o
);
  assign src_o = ldr_active_i ? ldr_value_i : ctl_field_i;
endmodule

// File: rtl/strobe_dec3to8.sv
module strobe_dec3to8 #(
  parameter int unsigned SEL_W = strobe_pkg::STRB_SEL_W,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_N-1:0] out_n_o
);
  genvar gi;
  generate
    for (gi = 0; gi < OUT_N; gi++) begin : g_line
      assign out_n_o[gi] = ~(en_i && (sel_i == SEL_W'(gi)));
    end
  endgenerate

  always_comb begin
    if (!en_i) begin
      AST_DEC_IDLE_WHEN_OFF: assert (&out_n_o) else $error("decoder active while disabled"); // R8
    end
    AST_DEC_ONE_LINE: assert ($countones(~out_n_o) <= 1) else $error("decoder drives two lines"); // R6
  end
endmodule

// File: rtl/strobe_group.sv
module strobe_group
  import strobe_pkg::*;
#(
  parameter int unsigned SEL_W  = STRB_SEL_W,
  parameter int unsigned PAIR_N = STRB_PAIR_N,
  parameter bit          PARK_ZERO = 1'b1,
  localparam int unsigned DEC_OUT = 1 << SEL_W,
  localparam int unsigned GRP_W   = PAIR_N * DEC_OUT,
  localparam int unsigned BANK_W  = (PAIR_N > 1) ? $clog2(PAIR_N) : 1,
  localparam int unsigned CODE_W  = SEL_W + BANK_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [GRP_W-1:0]  strb_n_o
);
  logic [BANK_W-1:0] bank_sel;
  logic [SEL_W-1:0]  line_sel;
  logic              code_is_zero;
  logic [GRP_W-1:0]  raw_n;

  assign bank_sel     = code_i[CODE_W-1:SEL_W];
  assign line_sel     = code_i[SEL_W-1:0];
  assign code_is_zero = (code_i == '0);

  genvar gb;
  generate
    for (gb = 0; gb < PAIR_N; gb++) begin : g_bank
      logic bank_en;
      assign bank_en = (bank_sel == BANK_W'(gb));
      strobe_dec3to8 #(.SEL_W(SEL_W)) u_dec (
        .en_i   (bank_en),
        .sel_i  (line_sel),
        .out_n_o(raw_n[gb*DEC_OUT +: DEC_OUT])
      );
    end
  endgenerate

  generate
    if (PARK_ZERO) begin : g_park
      // position 0 is unconnected: code zero means no strobe
      assign strb_n_o = {raw_n[GRP_W-1:1], 1'b1};
    end else begin : g_nopark
      assign strb_n_o = raw_n;
    end
  endgenerate

  always_comb begin
    if (!$isunknown(code_i)) begin
      AST_GRP_AT_MOST_ONE: assert ($countones(~strb_n_o) <= 1) else $error("two strobes in group"); // R6
      if (code_is_zero) begin
        AST_GRP_ZERO_IDLE: assert (&strb_n_o) else $error("strobe on code zero"); // R5
      end else begin
        AST_GRP_HIT_INDEX: assert (strb_n_o[code_i] == 1'b0) else $error("selected strobe not low"); // R3
      end
    end
  end
endmodule

// File: rtl/ctl_strobe_decoder.sv
module ctl_strobe_decoder
  import strobe_pkg::*;
(
  input  logic [7:0]  ctl_field_i,
  input  logic        ldr_active_i,
  input  logic [7:0]  ldr_value_i,
  output logic [15:0] rd_strb_n_o,
  output logic [15:0] wr_strb_n_o
);
  strb_field_t src;
  strb_code_t  rd_code;
  strb_code_t  wr_code;

  strobe_src_sel u_src (
    .ctl_field_i (ctl_field_i),
    .ldr_active_i(ldr_active_i),
    .ldr_value_i (ldr_value_i),
    .src_o       (src)
  );

  assign rd_code = rd_code_of(src);
  assign wr_code = wr_code_of(src);

  strobe_group #(.SEL_W(STRB_SEL_W), .PAIR_N(STRB_PAIR_N), .PARK_ZERO(1'b1)) u_rd_grp (
    .code_i  (rd_code),
    .strb_n_o(rd_strb_n_o)
  );

  strobe_group #(.SEL_W(STRB_SEL_W), .PAIR_N(STRB_PAIR_N), .PARK_ZERO(1'b1)) u_wr_grp (
    .code_i  (wr_code),
    .strb_n_o(wr_strb_n_o)
  );

  always_comb begin
    if (!$isunknown({ctl_field_i, ldr_active_i, ldr_value_i})) begin
      AST_UNUSED_SLOT_HIGH: assert (rd_strb_n_o[0] && wr_strb_n_o[0]) else $error("slot 0 driven"); // R5
      if (ldr_active_i && ldr_value_i[3:0] != 4'd0) begin
        AST_LDR_DRIVES_READ: assert (!rd_strb_n_o[ldr_value_i[3:0]]) else $error("loader read code lost"); // R2
      end
      if (!ldr_active_i && ctl_field_i[7:4] != 4'd0) begin
        AST_FIELD_DRIVES_WRITE: assert (!wr_strb_n_o[ctl_field_i[7:4]]) else $error("field write code lost"); // R1
      end
      if (bank_of(wr_code)) begin
        AST_UPPER_BANK_WRITE: assert (&wr_strb_n_o[7:0]) else $error("lower decoder active for upper code"); // R8
      end
    end
  end
endmodule

// File: tb/test_ctl_strobe_decoder.sv
module test_ctl_strobe_decoder;
  logic        clk = 1'b0;
  logic [7:0]  field;
  logic        ldr;
  logic [7:0]  ext;
  logic [15:0] rd_n;
  logic [15:0] wr_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  ctl_strobe_decoder i_ctl_strobe_decoder (
    .ctl_field_i (field),
    .ldr_active_i(ldr),
    .ldr_value_i (ext),
    .rd_strb_n_o (rd_n),
    .wr_strb_n_o (wr_n)
  );

  // expected strobe vector for a 4-bit code, written from the requirements
  function automatic logic [15:0] want(input logic [3:0] code);
    logic [15:0] v;
    v = 16'hFFFF;
    for (int k = 1; k < 16; k++) if (code == 4'(k)) v[k] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (field=%h ldr=%b ext=%h)", req, act, exp, field, ldr, ext);
    end
  endtask

  task automatic apply(input logic [7:0] f, input logic l, input logic [7:0] e);
    @(negedge clk);
    field = f; ldr = l; ext = e;
    #2;
  endtask

  task automatic t_idle();
    apply(8'h00, 1'b0, 8'h00);
    chk("R7 idle read", rd_n, 16'hFFFF);
    chk("R7 idle write", wr_n, 16'hFFFF);
  endtask

  task automatic t_field_path();
    apply(8'h5A, 1'b0, 8'h37);
    chk("R1 R3 read", rd_n, want(4'hA));
    chk("R1 R4 write", wr_n, want(4'h5));
  endtask

  task automatic t_override_path();
    apply(8'h5A, 1'b1, 8'h37);
    chk("R2 read from loader", rd_n, want(4'h7));
    chk("R2 write from loader", wr_n, want(4'h3));
    apply(8'hC9, 1'b1, 8'h37);
    chk("R2 field ignored read", rd_n, want(4'h7));
    chk("R2 field ignored write", wr_n, want(4'h3));
  endtask

  task automatic t_ext_ignored();
    apply(8'h21, 1'b0, 8'hFF);
    chk("R1 ext ignored read", rd_n, want(4'h1));
    chk("R1 ext ignored write", wr_n, want(4'h2));
  endtask

  task automatic t_zero_code();
    apply(8'hF0, 1'b0, 8'h00);
    chk("R5 zero read code", rd_n, 16'hFFFF);
    chk("R4 top write code", wr_n, 16'h7FFF);
    apply(8'h0F, 1'b1, 8'h0F);
    chk("R5 zero write code via loader", wr_n, 16'hFFFF);
  endtask

  task automatic t_bank_split();
    apply(8'h87, 1'b0, 8'h00);
    chk("R8 code 8 upper bank", wr_n, 16'hFEFF);
    chk("R8 code 7 lower bank", rd_n, 16'hFF7F);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] src;
        apply(m ? 8'(255 - v) : 8'(v), m[0], m ? 8'(v) : 8'(v ^ 8'h5C));
        src = m ? 8'(v) : 8'(v);
        chk(m ? "R2 R3 sweep read" : "R1 R3 sweep read", rd_n, want(src[3:0]));
        chk(m ? "R2 R4 sweep write" : "R1 R4 sweep write", wr_n, want(src[7:4]));
        checks++;
        if ($countones(~rd_n) > 1 || $countones(~wr_n) > 1 || !rd_n[0] || !wr_n[0]) begin
          errors++;
          $display("FAIL R6 R5: rd=%h wr=%h expected at most one low, bit0 high", rd_n, wr_n);
        end
      end
    end
  endtask

  initial begin
    field = 8'h00; ldr = 1'b0; ext = 8'h00;
    t_idle();
    t_field_path();
    t_override_path();
    t_ext_ignored();
    t_zero_code();
    t_bank_split();
    t_sweep();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule